// File: doc/BRIEF.md
# Two-wire register slave with four-way address strap

This block is the serial front end of a register-mapped peripheral on a two-wire (I2C) bus. It samples the clock and data lines with the system clock, finds START and STOP conditions, and takes in an address byte whose lowest bit selects the direction. It then handles a register-index byte and any number of data bytes. Writes go out through a simple register-file port as single-cycle strobes. Reads take data from that port. The register index advances after every data byte, so a burst covers consecutive registers. A repeated START followed by a read continues from the index reached so far.

The 7-bit slave address comes from one strap pin, which the board connects to ground, to supply, to the data line or to the clock line. The block works out which of the four connections is present. It watches the strap from the first START onward, compares it against both bus lines, and locks the answer when the first address byte completes. The slave drives the data line only as an open-drain pull-down through an output enable. It never drives the clock line.

Top module: `i2c_strap_slave`

## Requirements
- R1: After reset the data line is released and no write strobe is issued. A START (data falls while clock is high) begins a new frame from any state. A STOP (data rises while clock is high) abandons the current frame, and the next frame is received normally.
- R2: The slave acknowledges an address byte only when its upper seven bits equal 0111000 with the strap grounded, 0111010 with the strap at supply, 0111100 with the strap on the data line, or 0111110 with the strap on the clock line. Bit 0 of the address byte is the direction bit: 0 means write and 1 means read.
- R3: The strap connection is decided at the end of the first address byte after reset. It stays fixed until the next reset, even if the strap pin later behaves differently.
- R4: For every byte the master writes to a matching slave, the slave pulls the data line low through the high phase of the ninth clock.
- R5: The first byte after a write address sets the register index. Each later byte produces one single-cycle write strobe, with the index on the address output and the byte on the write-data output. The index then increments by one.
- R6: After a read address, the slave sends the register at the current index, most significant bit first, and increments the index for each byte sent. A later read frame continues from the advanced index.
- R7: During the ninth clock of a read byte, the slave releases the data line. If the master acknowledged (data low), the next byte follows. If the master did not acknowledge, the slave keeps the line released until the next START or STOP.
- R8: After an address that does not match, the slave sends no acknowledge, drives nothing and issues no write strobe until the next START or STOP.
- R9: The data-line output enable changes only while the sampled clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 1 | Address strap pin (ground, supply, data line or clock line) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| reg_addr | output | REG_AW | Current register index |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Byte to write at reg_addr |
| reg_rdata | input | 8 | Register contents at reg_addr, combinational from the register file |

## Verification
The bench runs every strap connection from reset. In each one it acknowledges its own address and refuses the address a neighbouring strap would give. A classifier that confuses the clock-line strap with supply would answer to the wrong address in that mode. The bench reads back a burst and then starts a second read frame without a new index. A slave that failed to advance or keep the index would return the wrong register. After the master's final not-acknowledge, the bench watches the data line, so a slave that loads and drives another byte shows up as a held-low line. The bench also moves the strap after the lock, sends a frame that dies mid-byte under STOP, and follows a foreign address with data bytes. These expose a classifier that keeps re-deciding, a receiver left in a half-byte state, and a slave that acknowledges or writes after a mismatch.

// File: rtl/i2c_strap_pkg.sv
`timescale 1ns/1ps
package i2c_strap_pkg;
  typedef enum logic [1:0] {
    STRAP_GND = 2'd0,
    STRAP_VCC = 2'd1,
    STRAP_SDA = 2'd2,
    STRAP_SCL = 2'd3
  } strap_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_REGA, PH_WDAT, PH_RDAT
  } phase_e;

  localparam logic [6:0] ADDR_BASE = 7'b0111000;

  function automatic logic [6:0] slave_addr(input strap_e c);
    return ADDR_BASE | {4'b0000, c, 1'b0};
  endfunction
endpackage

// File: rtl/i2c_sync.sv
`timescale 1ns/1ps
module i2c_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = W * STAGES;
  logic [CW-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[CW-W-1:0], d};
  end

  assign q = chain[CW-1 -: W];
endmodule

// File: rtl/i2c_strap_classify.sv
`timescale 1ns/1ps
module i2c_strap_classify
  import i2c_strap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   track,
  input  logic   decide,
  input  logic   strap_s,
  input  logic   sda_s,
  input  logic   scl_s,
  output logic   valid,
  output strap_e cls,
  output logic   locked
);
  logic   seen0_q, seen1_q, dsda_q, dscl_q, lock_q;
  strap_e lcls_q;
  logic   seen0_n, seen1_n, dsda_n, dscl_n, cand_v;
  strap_e cand_c;

  always_comb begin
    seen0_n = seen0_q | (track & ~strap_s);
    seen1_n = seen1_q | (track & strap_s);
    dsda_n  = dsda_q  | (track & (strap_s ^ sda_s));
    dscl_n  = dscl_q  | (track & (strap_s ^ scl_s));
    cand_v  = 1'b1;
    cand_c  = STRAP_GND;
    if (!seen1_n)      cand_c = STRAP_GND;
    else if (!seen0_n) cand_c = STRAP_VCC;
    else if (!dsda_n)  cand_c = STRAP_SDA;
    else if (!dscl_n)  cand_c = STRAP_SCL;
    else               cand_v = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen0_q <= 1'b0;
      seen1_q <= 1'b0;
      dsda_q  <= 1'b0;
      dscl_q  <= 1'b0;
      lock_q  <= 1'b0;
      lcls_q  <= STRAP_GND;
    end else begin
      if (track) begin
        seen0_q <= seen0_n;
        seen1_q <= seen1_n;
        dsda_q  <= dsda_n;
        dscl_q  <= dscl_n;
      end
      if (decide && !lock_q && cand_v) begin
        lock_q <= 1'b1;
        lcls_q <= cand_c;
      end
    end
  end

  assign valid  = lock_q | cand_v;
  assign cls    = lock_q ? lcls_q : cand_c;
  assign locked = lock_q;
endmodule

// File: rtl/i2c_strap_slave.sv
`timescale 1ns/1ps
module i2c_strap_slave
  import i2c_strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  output logic              sda_oe,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_we,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] LAST_BIT = 4'd7;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  logic [2:0] pins_s;
  logic       scl_s, sda_s, strap_s, scl_q, sda_q;

  i2c_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n_sync), .d({scl_i, sda_i, strap_i}), .q(pins_s)
  );
  assign {scl_s, sda_s, strap_s} = pins_s;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  phase_e            phase_q, phase_n, after_q, after_n, next_ph;
  logic [3:0]        bit_q, bit_n;
  logic              ackph_q, ackph_n, mnack_q, mnack_n, oe_q, oe_n, we_q, we_n;
  logic [7:0]        sh_q, sh_n, wd_q, wd_n, byte_in;
  logic [REG_AW-1:0] ptr_q, ptr_n;
  logic              decide, st_valid, st_locked, track;
  strap_e            st_cls;

  assign track = start_c | (phase_q != PH_IDLE);

  i2c_strap_classify u_cls (
    .clk(clk), .rst_n(rst_n_sync), .track(track), .decide(decide),
    .strap_s(strap_s), .sda_s(sda_s), .scl_s(scl_s),
    .valid(st_valid), .cls(st_cls), .locked(st_locked)
  );

  assign byte_in = {sh_q[6:0], sda_s};

  always_comb begin
    phase_n = phase_q;
    after_n = after_q;
    bit_n   = bit_q;
    ackph_n = ackph_q;
    mnack_n = mnack_q;
    oe_n    = oe_q;
    sh_n    = sh_q;
    wd_n    = wd_q;
    ptr_n   = ptr_q;
    we_n    = 1'b0;
    decide  = 1'b0;
    next_ph = after_q;
    if (we_q) ptr_n = ptr_q + 1'b1;
    if (stop_c || start_c) begin
      phase_n = stop_c ? PH_IDLE : PH_ADDR;
      oe_n    = 1'b0;
      bit_n   = '0;
      ackph_n = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        if (bit_q != ACK_SLOT) begin
          bit_n = bit_q + 1'b1;
          if (phase_q != PH_RDAT) begin
            sh_n = byte_in;
            if (bit_q == LAST_BIT) begin
              case (phase_q)
                PH_ADDR: begin
                  decide = 1'b1;
                  if (st_valid && byte_in[7:1] == slave_addr(st_cls))
                    after_n = byte_in[0] ? PH_RDAT : PH_REGA;
                  else begin
                    phase_n = PH_IDLE;
                    bit_n   = '0;
                  end
                end
                PH_REGA: begin
                  ptr_n   = byte_in[REG_AW-1:0];
                  after_n = PH_WDAT;
                end
                default: begin
                  we_n    = 1'b1;
                  wd_n    = byte_in;
                  after_n = PH_WDAT;
                end
              endcase
            end
          end
        end else if (ackph_q) begin
          mnack_n = sda_s;
        end
      end else if (scl_fall) begin
        if (bit_q == ACK_SLOT && !ackph_q) begin
          ackph_n = 1'b1;
          oe_n    = (phase_q != PH_RDAT);
        end else if (ackph_q) begin
          ackph_n = 1'b0;
          bit_n   = '0;
          oe_n    = 1'b0;
          if (phase_q == PH_RDAT) next_ph = mnack_q ? PH_IDLE : PH_RDAT;
          phase_n = next_ph;
          if (next_ph == PH_RDAT) begin
            sh_n  = reg_rdata;
            oe_n  = ~reg_rdata[7];
            ptr_n = ptr_q + 1'b1;
          end
        end else if (phase_q == PH_RDAT && bit_q != '0) begin
          sh_n = {sh_q[6:0], 1'b0};
          oe_n = ~sh_q[6];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      phase_q <= PH_IDLE;
      after_q <= PH_IDLE;
      bit_q   <= '0;
      ackph_q <= 1'b0;
      mnack_q <= 1'b1;
      oe_q    <= 1'b0;
      sh_q    <= '0;
      wd_q    <= '0;
      ptr_q   <= '0;
      we_q    <= 1'b0;
    end else begin
      scl_q   <= scl_s;
      sda_q   <= sda_s;
      phase_q <= phase_n;
      after_q <= after_n;
      bit_q   <= bit_n;
      ackph_q <= ackph_n;
      mnack_q <= mnack_n;
      oe_q    <= oe_n;
      sh_q    <= sh_n;
      wd_q    <= wd_n;
      ptr_q   <= ptr_n;
      we_q    <= we_n;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_we    = we_q;
  assign reg_wdata = wd_q;
endmodule

// File: rtl/i2c_strap_checker.sv
`timescale 1ns/1ps
module i2c_strap_checker #(
  parameter int REG_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              idle,
  input logic              locked,
  input logic [1:0]        cls
);
  a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == REG_AW'($past(reg_addr) + 1'b1));

  a_r3_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(cls));

  a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    idle && $past(idle) |-> !sda_oe);

  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

bind i2c_strap_slave i2c_strap_checker #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .scl_s(scl_s), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_addr(reg_addr), .idle(phase_q == i2c_strap_pkg::PH_IDLE),
  .locked(st_locked), .cls(st_cls)
);

// File: tb/i2c_strap_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_strap_slave_tb_top;
  localparam int Q = 6;

  logic       clk, rst_n, scl_m, sda_m, strap_w, sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire        sda_line = sda_m & ~sda_oe;
  int         mode, vectors, miscompares;
  bit         done;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] exp_q [$];

  i2c_strap_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap_w),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always_comb begin
    case (mode)
      0:       strap_w = 1'b0;
      1:       strap_w = 1'b1;
      2:       strap_w = sda_line;
      default: strap_w = scl_m;
    endcase
  end

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for register writes
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [15:0] it;
        it = exp_q.pop_front();
        check({reg_addr, reg_wdata} == it, "R5 write strobe", {reg_addr, reg_wdata}, it);
      end
    end
  end

  // R9: enable edges only while the clock line is low
  logic prev_oe;
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe) check(!scl_m, "R9 oe moved with SCL high", scl_m, 0);
    prev_oe <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    r = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic nack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      d[i] = r;
    end
    bit_io(nack, r);
  endtask

  task automatic run_mode(input int m);
    logic [6:0] a, wa;
    logic [7:0] rg, d, idx;
    logic       ack, r;
    mode = m;
    rst_n = 1'b0; tick(5);
    rst_n = 1'b1; tick(8);
    check(sda_oe == 1'b0 && reg_we == 1'b0, "R1 reset state", {sda_oe, reg_we}, 0);
    a  = 7'b0111000 | 7'(m << 1);
    wa = 7'b0111000 | 7'(((m + 1) % 4) << 1);
    rg = 8'h20 + 8'(m * 16);
    if (m == 0) begin
      bus_start(); bit_io(1'b0, r); bit_io(1'b1, r); bit_io(1'b1, r); bus_stop();
    end
    // burst write
    bus_start();
    wbyte({a, 1'b0}, ack); check(ack, "R2 own address acked", ack, 1);
    wbyte(rg, ack);        check(ack, "R4 index byte acked", ack, 1);
    for (int k = 0; k < 3; k++) begin
      d = 8'hA0 + 8'(m * 4 + k);
      idx = rg + 8'(k);
      exp_q.push_back({idx, d});
      exp_mem[idx] = d;
      wbyte(d, ack); check(ack, "R4 data byte acked", ack, 1);
    end
    bus_stop();
    check(exp_q.size() == 0, "R5 all writes seen", exp_q.size(), 0);
    // read back through repeated START
    bus_start();
    wbyte({a, 1'b0}, ack);
    wbyte(rg, ack);
    bus_rstart();
    wbyte({a, 1'b1}, ack); check(ack, "R6 read address acked", ack, 1);
    for (int k = 0; k < 3; k++) begin
      rbyte(d, k == 2);
      check(d == exp_mem[rg + 8'(k)], "R6 read data", d, exp_mem[rg + 8'(k)]);
    end
    for (int k = 0; k < 4; k++) begin
      tick(5);
      check(sda_oe == 1'b0, "R7 released after master NACK", sda_oe, 0);
    end
    bus_stop();
    // new read frame continues from advanced index
    bus_start();
    wbyte({a, 1'b1}, ack);
    rbyte(d, 1'b1);
    check(d == exp_mem[rg + 8'd3], "R6 index carried across frames", d, exp_mem[rg + 8'd3]);
    bus_stop();
    // foreign address then data: silence
    bus_start();
    wbyte({wa, 1'b0}, ack); check(!ack, "R8 foreign address not acked", ack, 0);
    wbyte(8'h55, ack);      check(!ack, "R8 byte after mismatch not acked", ack, 0);
    wbyte(8'h00, ack);      check(!ack, "R8 zero byte after mismatch not acked", ack, 0);
    bus_stop();
    check(exp_q.size() == 0, "R8 no write after mismatch", exp_q.size(), 0);
  endtask

  initial begin
    logic ack;
    vectors = 0; miscompares = 0; done = 1'b0; prev_oe = 1'b0;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    scl_m = 1'b1; sda_m = 1'b1; mode = 0; rst_n = 1'b0;
    run_mode(0);
    // R3: strap moves to supply without reset, grounded address stays
    mode = 1;
    bus_start(); wbyte(8'b0111_0100, ack); bus_stop();
    check(!ack, "R3 supply address refused after lock", ack, 0);
    bus_start(); wbyte(8'b0111_0000, ack); bus_stop();
    check(ack, "R3 locked address still acked", ack, 1);
    for (int m = 1; m < 4; m++) run_mode(m);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule